// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous DRAM

This block sits between a synchronous host and an asynchronous DRAM with a 16-bit data bus split into two byte lanes. The DRAM takes its address in two halves on one shared set of pins. It has a single row strobe and one column strobe per byte lane. The host raises a request with an address, write data, a two-bit lane enable and a direction flag. It holds the request until the block returns a one-cycle acknowledge, which for reads carries the captured data.

After reset the block first waits out a long start-up pause. It then issues eight column-before-row refresh cycles and only then serves host traffic. From that point a free-running refresh timer marks a refresh as due at a fixed interval. The refresh is slotted in between host cycles and wins over a waiting request. Writes use early-write timing: the write strobe is low before any column strobe falls, so the DRAM never drives the bus and the block drives the write data itself. Every DRAM interval is a parameter counted in clock cycles.

Top module: `dram_lane_ctrl`

## Requirements
- R1: After reset the row strobe stays high for at least T_PAUSE cycles. Exactly INIT_REFS (8) refresh cycles follow before the first host access, and no acknowledge is given before that access.
- R2: Whenever the row strobe is high, and during every refresh, the block does not drive the data bus (`dram_dq_oe` low).
- R3: `host_be[0]` selects the lower lane (bits 7:0, strobe `dram_lcas_n`) and `host_be[1]` selects the upper lane (bits 15:8, strobe `dram_ucas_n`). Only the selected strobes fall during an access. A lane that was not selected reads back as zero.
- R4: The upper ROW_W bits of `host_addr` are on `dram_addr` when the row strobe falls. The lower COL_W bits are on `dram_addr` when the column strobes fall.
- R5: A read keeps `dram_we_n` high and `dram_oe_n` low. Data is sampled T_RAC cycles after the row strobe falls and returned on `host_rdata` with `host_ack` high for exactly one cycle.
- R6: A write pulls `dram_we_n` low before any column strobe falls and keeps `dram_oe_n` high. It drives the host write data, unchanged, on `dram_dq_out` with `dram_dq_oe` high while the column strobes are low.
- R7: At least T_CP cycles separate the last column-strobe rise of one cycle from the first column-strobe fall of the next. The row strobe is high for at least T_RP cycles between row-strobe low periods.
- R8: `dram_we_n` never changes while the row strobe stays low or while any column strobe is low.
- R9: After initialisation a refresh starts at least once every T_REFI cycles plus at most one host access. A refresh never interrupts a host access.
- R10: In a refresh both column strobes fall together while the row strobe is high. At least T_CSR cycles later the row strobe falls and stays low for at least T_RAS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_be | input | 2 | Lane enables: bit 0 lower byte, bit 1 upper byte |
| host_addr | input | ROW_W+COL_W | Word address; upper ROW_W bits are the row |
| host_wdata | input | 2*LANE_W | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 2*LANE_W | Read data, valid with host_ack |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-lane column strobe, active low |
| dram_ucas_n | output | 1 | Upper-lane column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 2*LANE_W | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | High when the block drives the data bus |
| dram_dq_in | input | 2*LANE_W | Data returned from the DRAM |

## Verification
The embedded properties assume the host keeps `host_req` and its fields steady until `host_ack`, drops the request right after, and never asks with `host_be` equal to zero. The bench's access task raises the request on a falling edge, waits for the acknowledge, and lowers it on that same falling edge. Random stimulus draws only the three legal lane patterns. A behavioural DRAM model in the bench latches row and column on the strobe edges and answers reads only while the lane strobe, the output enable and the write strobe allow it. A shadow array, updated only from the host's own writes, supplies the expected read values.

// File: rtl/dram_lane_pkg.sv
package dram_lane_pkg;

    localparam int unsigned LANES = 2;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_PRE,
        ST_CBR_CAS,
        ST_CBR_RAS
    } seq_state_e;

    typedef enum logic {
        ADDR_ROW = 1'b0,
        ADDR_COL = 1'b1
    } addr_sel_e;

    typedef struct packed {
        logic ras_n;
        logic lcas_n;
        logic ucas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, lcas_n: 1'b1, ucas_n: 1'b1,
                                        we_n: 1'b1, oe_n: 1'b1};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dlc_refresh_timer.sv
module dlc_refresh_timer
    import dram_lane_pkg::*;
#(
    parameter int unsigned T_REFI = 3900
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic take,
    output logic pending
);
    localparam int unsigned CW = $clog2(T_REFI + 1);

    logic [CW-1:0] cnt_q;
    logic          pend_q;
    logic          wrap;

    assign wrap    = enable && (cnt_q == CW'(T_REFI - 1));
    assign pending = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (!enable || wrap) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
            pend_q <= (pend_q && !take) || wrap;
        end
    end

    // A due refresh is only dropped when the sequencer takes it (R9)
    p_pending_held_r9: assert property (@(posedge clk) disable iff (rst)
        (pending && !take) |=> pending);

endmodule

// File: rtl/dlc_sequencer.sv
module dlc_sequencer
    import dram_lane_pkg::*;
#(
    parameter int unsigned T_PAUSE   = 50000,
    parameter int unsigned INIT_REFS = 8,
    parameter int unsigned T_RP      = 8,
    parameter int unsigned T_RCD     = 4,
    parameter int unsigned T_CAS     = 3,
    parameter int unsigned T_CP      = 3,
    parameter int unsigned T_RAC     = 12,
    parameter int unsigned T_CSR     = 2,
    parameter int unsigned T_RAS     = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [1:0]  host_be,
    input  logic        ref_pending,
    output logic        ref_take,
    output logic        init_done,
    output logic        latch_req,
    output strobe_t     strobes,
    output addr_sel_e   addr_sel,
    output logic        drive_en,
    output logic        capture,
    output logic        ack
);
    localparam int unsigned T_COL  = max2(T_CAS, T_RAC - T_RCD + 1);
    localparam int unsigned T_PRE  = max2(T_RP, T_CP);
    localparam int unsigned CMAX   = max2(max2(max2(T_PAUSE, T_COL), max2(T_RCD, T_PRE)),
                                          max2(T_CSR, T_RAS));
    localparam int unsigned CNT_W  = $clog2(CMAX + 1);
    localparam int unsigned AGE_W  = $clog2(T_RCD + T_COL + 1);
    localparam int unsigned INIT_W = $clog2(INIT_REFS + 1);

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [AGE_W-1:0]  age_q;
    logic [INIT_W-1:0] init_left_q;
    logic              we_q;
    logic [1:0]        be_q;
    logic              ack_q;
    logic              init_done_q;
    logic              cnt_zero;

    assign cnt_zero  = (cnt_q == '0);
    assign init_done = init_done_q;
    assign ack       = ack_q;
    assign ref_take  = (state_q == ST_IDLE) && ref_pending;
    assign latch_req = (state_q == ST_IDLE) && !ref_pending && host_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_PAUSE;
            cnt_q       <= CNT_W'(T_PAUSE - 1);
            age_q       <= '0;
            init_left_q <= INIT_W'(INIT_REFS);
            we_q        <= 1'b0;
            be_q        <= 2'b00;
            ack_q       <= 1'b0;
            init_done_q <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (state_q == ST_ROW || state_q == ST_COL) age_q <= age_q + 1'b1;
            else                                         age_q <= '0;
            if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
            unique case (state_q)
                ST_PAUSE: if (cnt_zero) begin
                    state_q <= ST_CBR_CAS;
                    cnt_q   <= CNT_W'(T_CSR - 1);
                end
                ST_IDLE: begin
                    if (ref_pending) begin
                        state_q <= ST_CBR_CAS;
                        cnt_q   <= CNT_W'(T_CSR - 1);
                        we_q    <= 1'b0;
                    end else if (host_req) begin
                        state_q <= ST_ROW;
                        cnt_q   <= CNT_W'(T_RCD - 1);
                        we_q    <= host_we;
                        be_q    <= host_be;
                    end
                end
                ST_ROW: if (cnt_zero) begin
                    state_q <= ST_COL;
                    cnt_q   <= CNT_W'(T_COL - 1);
                end
                ST_COL: if (cnt_zero) begin
                    state_q <= ST_PRE;
                    cnt_q   <= CNT_W'(T_PRE - 1);
                    ack_q   <= 1'b1;
                end
                ST_CBR_CAS: if (cnt_zero) begin
                    state_q <= ST_CBR_RAS;
                    cnt_q   <= CNT_W'(T_RAS - 1);
                end
                ST_CBR_RAS: if (cnt_zero) begin
                    state_q <= ST_PRE;
                    cnt_q   <= CNT_W'(T_PRE - 1);
                    if (!init_done_q && init_left_q != '0) init_left_q <= init_left_q - 1'b1;
                end
                ST_PRE: if (cnt_zero) begin
                    if (!init_done_q && init_left_q != '0) begin
                        state_q <= ST_CBR_CAS;
                        cnt_q   <= CNT_W'(T_CSR - 1);
                    end else begin
                        state_q     <= ST_IDLE;
                        init_done_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        strobes  = STROBE_IDLE;
        addr_sel = ADDR_ROW;
        drive_en = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_ROW: begin
                strobes.ras_n = 1'b0;
                strobes.we_n  = !we_q;
                strobes.oe_n  = we_q;
                drive_en      = we_q;
            end
            ST_COL: begin
                strobes.ras_n  = 1'b0;
                strobes.lcas_n = !be_q[0];
                strobes.ucas_n = !be_q[1];
                strobes.we_n   = !we_q;
                strobes.oe_n   = we_q;
                addr_sel       = ADDR_COL;
                drive_en       = we_q;
                capture        = !we_q && (age_q == AGE_W'(T_RAC));
            end
            ST_PRE:     strobes.we_n = !we_q;
            ST_CBR_CAS: begin
                strobes.lcas_n = 1'b0;
                strobes.ucas_n = 1'b0;
            end
            ST_CBR_RAS: begin
                strobes.ras_n  = 1'b0;
                strobes.lcas_n = 1'b0;
                strobes.ucas_n = 1'b0;
            end
            default: ;
        endcase
    end

    // No acknowledge until start-up refreshes are complete (R1)
    p_no_ack_in_init_r1: assert property (@(posedge clk) disable iff (rst)
        !init_done_q |-> !ack_q);

    // Acknowledge is a single-cycle pulse (R5)
    p_ack_single_r5: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q);

    // Write strobe frozen across a continuous row-low period (R8)
    p_we_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!strobes.ras_n && $past(!strobes.ras_n)) |-> $stable(strobes.we_n));

    // Column strobe falling with row high is a refresh: both lanes together (R10)
    p_cbr_both_lanes_r10: assert property (@(posedge clk) disable iff (rst)
        ($fell(strobes.lcas_n) && strobes.ras_n) |-> !strobes.ucas_n);

endmodule

// File: rtl/dlc_datapath.sv
module dlc_datapath
    import dram_lane_pkg::*;
#(
    parameter int unsigned ROW_W  = 12,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned LANE_W = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                latch_req,
    input  logic [ROW_W+COL_W-1:0]              host_addr,
    input  logic [LANES*LANE_W-1:0]             host_wdata,
    input  logic [LANES-1:0]                    host_be,
    input  addr_sel_e                           addr_sel,
    input  logic                                drive_en,
    input  logic                                capture,
    input  logic [LANES*LANE_W-1:0]             dq_in,
    output logic [max2(ROW_W, COL_W)-1:0]       dram_addr,
    output logic [LANES*LANE_W-1:0]             dq_out,
    output logic                                dq_oe,
    output logic [LANES*LANE_W-1:0]             rdata
);
    localparam int unsigned ADDR_W = ROW_W + COL_W;
    localparam int unsigned MA_W   = max2(ROW_W, COL_W);

    logic [ADDR_W-1:0]          addr_q;
    logic [LANES*LANE_W-1:0]    wdata_q;
    logic [LANES-1:0]           be_q;
    logic [MA_W-1:0]            row_addr;
    logic [MA_W-1:0]            col_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (latch_req) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            be_q    <= host_be;
        end
    end

    assign row_addr  = MA_W'(addr_q[ADDR_W-1 -: ROW_W]);
    assign col_addr  = MA_W'(addr_q[COL_W-1:0]);
    assign dram_addr = (addr_sel == ADDR_COL) ? col_addr : row_addr;
    assign dq_out    = wdata_q;
    assign dq_oe     = drive_en;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)          lane_q <= '0;
            else if (capture) lane_q <= be_q[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
        end
        assign rdata[g*LANE_W +: LANE_W] = lane_q;
    end

    // Write data held steady while driven onto the bus (R6)
    p_wdata_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

endmodule

// File: rtl/dram_lane_ctrl.sv
module dram_lane_ctrl
    import dram_lane_pkg::*;
#(
    parameter int unsigned ROW_W     = 12,
    parameter int unsigned COL_W     = 10,
    parameter int unsigned LANE_W    = 8,
    parameter int unsigned T_PAUSE   = 50000,
    parameter int unsigned INIT_REFS = 8,
    parameter int unsigned T_RP      = 8,
    parameter int unsigned T_RCD     = 4,
    parameter int unsigned T_CAS     = 3,
    parameter int unsigned T_CP      = 3,
    parameter int unsigned T_RAC     = 12,
    parameter int unsigned T_CSR     = 2,
    parameter int unsigned T_RAS     = 12,
    parameter int unsigned T_REFI    = 3900
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              host_req,
    input  logic                              host_we,
    input  logic [1:0]                        host_be,
    input  logic [ROW_W+COL_W-1:0]            host_addr,
    input  logic [2*LANE_W-1:0]               host_wdata,
    output logic                              host_ack,
    output logic [2*LANE_W-1:0]               host_rdata,
    output logic [max2(ROW_W, COL_W)-1:0]     dram_addr,
    output logic                              dram_ras_n,
    output logic                              dram_lcas_n,
    output logic                              dram_ucas_n,
    output logic                              dram_we_n,
    output logic                              dram_oe_n,
    output logic [2*LANE_W-1:0]               dram_dq_out,
    output logic                              dram_dq_oe,
    input  logic [2*LANE_W-1:0]               dram_dq_in
);
    logic      ref_pending;
    logic      ref_take;
    logic      init_done;
    logic      latch_req;
    strobe_t   strobes;
    addr_sel_e addr_sel;
    logic      drive_en;
    logic      capture;

    dlc_refresh_timer #(.T_REFI(T_REFI)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .enable  (init_done),
        .take    (ref_take),
        .pending (ref_pending)
    );

    dlc_sequencer #(
        .T_PAUSE(T_PAUSE), .INIT_REFS(INIT_REFS), .T_RP(T_RP), .T_RCD(T_RCD),
        .T_CAS(T_CAS), .T_CP(T_CP), .T_RAC(T_RAC), .T_CSR(T_CSR), .T_RAS(T_RAS)
    ) i_seq (
        .clk         (clk),
        .rst         (rst),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_be     (host_be),
        .ref_pending (ref_pending),
        .ref_take    (ref_take),
        .init_done   (init_done),
        .latch_req   (latch_req),
        .strobes     (strobes),
        .addr_sel    (addr_sel),
        .drive_en    (drive_en),
        .capture     (capture),
        .ack         (host_ack)
    );

    dlc_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .LANE_W(LANE_W)) i_dp (
        .clk        (clk),
        .rst        (rst),
        .latch_req  (latch_req),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_be    (host_be),
        .addr_sel   (addr_sel),
        .drive_en   (drive_en),
        .capture    (capture),
        .dq_in      (dram_dq_in),
        .dram_addr  (dram_addr),
        .dq_out     (dram_dq_out),
        .dq_oe      (dram_dq_oe),
        .rdata      (host_rdata)
    );

    assign dram_ras_n  = strobes.ras_n;
    assign dram_lcas_n = strobes.lcas_n;
    assign dram_ucas_n = strobes.ucas_n;
    assign dram_we_n   = strobes.we_n;
    assign dram_oe_n   = strobes.oe_n;

    // Bus released whenever the row strobe is high (R2)
    p_standby_hiz_r2: assert property (@(posedge clk) disable iff (rst)
        dram_ras_n |-> !dram_dq_oe);

endmodule

// File: tb/test_dram_lane_ctrl.sv
module test_dram_lane_ctrl;
    localparam int ROW_W = 4, COL_W = 4, LANE_W = 8;
    localparam int T_PAUSE = 100, INIT_REFS = 8, T_RP = 3, T_RCD = 2, T_CAS = 2;
    localparam int T_CP = 2, T_RAC = 4, T_CSR = 1, T_RAS = 4, T_REFI = 150;
    localparam int T_COL = 3, T_PRE = 3;
    localparam int INIT_LEN = T_PAUSE + INIT_REFS * (T_CSR + T_RAS + T_PRE);
    localparam int GAP_MAX = T_REFI + T_RCD + T_COL + T_PRE + 2;

    logic clk = 0, rst = 1;
    logic host_req = 0, host_we = 0;
    logic [1:0] host_be = 0;
    logic [7:0] host_addr = 0;
    logic [15:0] host_wdata = 0;
    logic host_ack;
    logic [15:0] host_rdata, dram_dq_out, dram_dq_in;
    logic [3:0] dram_addr;
    logic dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;

    always #2 clk = ~clk;

    dram_lane_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .LANE_W(LANE_W), .T_PAUSE(T_PAUSE),
        .INIT_REFS(INIT_REFS), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
        .T_RAC(T_RAC), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_REFI(T_REFI)
    ) i_dram_lane_ctrl (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we), .host_be(host_be),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    int checks = 0, errors = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] seed_word(input int idx);
        return 16'(idx * 16'h0123) ^ 16'hA55A;
    endfunction

    // DRAM model and shadow copy
    logic [15:0] mem [256];
    logic [15:0] shadow [256];
    logic [3:0] row_m = 0, col_m = 0;
    logic col_valid = 0;
    logic rd_drive;
    assign rd_drive = !dram_ras_n && col_valid && !dram_oe_n && dram_we_n;
    assign dram_dq_in[7:0]  = (rd_drive && !dram_lcas_n) ? mem[{row_m, col_m}][7:0]  : 8'h5A;
    assign dram_dq_in[15:8] = (rd_drive && !dram_ucas_n) ? mem[{row_m, col_m}][15:8] : 8'hC3;

    // Monitor state
    logic p_ras = 1, p_l = 1, p_u = 1, p_we = 1;
    int cp_cnt = 1000, rp_cnt = 1000, csr_cnt = 0, ras_low = 0;
    bit in_cbr = 0, seen_access = 0;
    int ref_count = 0, last_ref = 0, first_cas = -1;
    logic [1:0] lane_seen = 0;
    logic [3:0] cur_row = 0, cur_col = 0;
    logic [15:0] cur_wdata = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            bit lfall, ufall;
            lfall = p_l && !dram_lcas_n;
            ufall = p_u && !dram_ucas_n;
            if (dram_ras_n) chk(!dram_dq_oe, "R2 bus driven with row high", dram_dq_oe, 0);
            if (in_cbr) chk(!dram_dq_oe, "R2 bus driven in refresh", dram_dq_oe, 0);
            if ((dram_we_n !== p_we) &&
                ((!dram_ras_n && !p_ras) || !dram_lcas_n || !dram_ucas_n || !p_l || !p_u))
                chk(0, "R8 write strobe moved", dram_we_n, p_we);
            if (lfall || ufall) begin
                if (first_cas < 0) begin
                    first_cas = cyc;
                    chk(cyc >= T_PAUSE, "R1 pause too short", cyc, T_PAUSE);
                end
                chk(cp_cnt >= T_CP, "R7 column precharge", cp_cnt, T_CP);
                if (dram_ras_n) begin
                    chk(lfall && ufall, "R10 lanes fall together", {ufall, lfall}, 3);
                    in_cbr = 1;
                    ref_count++;
                    if (ref_count > INIT_REFS + 1)
                        chk(cyc - last_ref <= GAP_MAX, "R9 refresh gap", cyc - last_ref, GAP_MAX);
                    last_ref = cyc;
                end else begin
                    col_m = dram_addr;
                    col_valid = 1;
                    chk(dram_addr == cur_col, "R4 column address", dram_addr, cur_col);
                    lane_seen = {ufall, lfall};
                    if (!dram_we_n) begin
                        chk(dram_oe_n && dram_dq_oe, "R6 write bus control",
                            {dram_oe_n, dram_dq_oe}, 3);
                        chk(dram_dq_out == cur_wdata, "R6 write data", dram_dq_out, cur_wdata);
                        if (ufall) mem[{row_m, col_m}][15:8] = dram_dq_out[15:8];
                        if (lfall) mem[{row_m, col_m}][7:0]  = dram_dq_out[7:0];
                    end else begin
                        chk(!dram_oe_n && !dram_dq_oe, "R5 read bus control",
                            {dram_oe_n, dram_dq_oe}, 0);
                    end
                end
            end
            if (p_ras && !dram_ras_n) begin
                chk(rp_cnt >= T_RP, "R7 row precharge", rp_cnt, T_RP);
                if (in_cbr) begin
                    chk(csr_cnt >= T_CSR, "R10 column-before-row setup", csr_cnt, T_CSR);
                end else begin
                    row_m = dram_addr;
                    chk(dram_addr == cur_row, "R4 row address", dram_addr, cur_row);
                    if (!seen_access) begin
                        seen_access = 1;
                        chk(ref_count == INIT_REFS, "R1 start-up refresh count",
                            ref_count, INIT_REFS);
                    end
                end
            end
            if (!p_ras && dram_ras_n && in_cbr)
                chk(ras_low >= T_RAS, "R10 refresh row low time", ras_low, T_RAS);
            cp_cnt  = (dram_lcas_n && dram_ucas_n) ? cp_cnt + 1 : 0;
            rp_cnt  = dram_ras_n ? rp_cnt + 1 : 0;
            csr_cnt = (dram_ras_n && !dram_lcas_n) ? csr_cnt + 1 : 0;
            ras_low = !dram_ras_n ? ras_low + 1 : 0;
            if (dram_lcas_n && dram_ucas_n) begin
                col_valid = 0;
                in_cbr = 0;
            end
            p_ras = dram_ras_n; p_l = dram_lcas_n; p_u = dram_ucas_n; p_we = dram_we_n;
        end
    end

    task automatic access(input bit we, input logic [1:0] be, input logic [7:0] addr,
                          input logic [15:0] wd);
        logic [15:0] exp;
        @(negedge clk);
        cur_row = addr[7:4]; cur_col = addr[3:0]; cur_wdata = wd; lane_seen = 0;
        host_req = 1; host_we = we; host_be = be; host_addr = addr; host_wdata = wd;
        @(negedge clk);
        while (!host_ack) @(negedge clk);
        host_req = 0;
        chk(lane_seen == be, "R3 lane strobes", lane_seen, be);
        if (!we) begin
            exp = {be[1] ? shadow[addr][15:8] : 8'h00, be[0] ? shadow[addr][7:0] : 8'h00};
            chk(host_rdata == exp, "R5 R3 read data", host_rdata, exp);
        end else begin
            if (be[1]) shadow[addr][15:8] = wd[15:8];
            if (be[0]) shadow[addr][7:0]  = wd[7:0];
        end
        @(negedge clk);
        chk(!host_ack, "R5 ack one cycle", host_ack, 0);
    endtask

    initial begin
        int start, refs_before;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) begin
            mem[i] = seed_word(i);
            shadow[i] = seed_word(i);
        end
        repeat (3) @(negedge clk);
        rst = 0;
        chk(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n && dram_oe_n && !dram_dq_oe
            && !host_ack, "R1 reset state", {dram_ras_n, dram_lcas_n, dram_ucas_n}, 3'b111);
        start = cyc;
        access(0, 2'b11, 8'h37, 0);
        chk(cyc - start > INIT_LEN, "R1 first ack after start-up", cyc - start, INIT_LEN);
        access(1, 2'b11, 8'h00, 16'h1234);
        access(0, 2'b11, 8'h00, 0);
        access(1, 2'b01, 8'hFF, 16'hAAEE);
        access(1, 2'b10, 8'hF0, 16'h7711);
        access(0, 2'b11, 8'hFF, 0);
        access(0, 2'b01, 8'hF0, 0);
        access(0, 2'b10, 8'hF0, 0);
        access(0, 2'b10, 8'hFF, 0);
        for (int n = 0; n < 300; n++) begin
            logic [1:0] be;
            be = 2'(($urandom % 3) + 1);
            access(1'($urandom % 2), be, 8'($urandom), 16'($urandom));
        end
        refs_before = ref_count;
        repeat (3 * T_REFI + 20) @(negedge clk);
        chk(ref_count - refs_before >= 3, "R9 idle refresh rate", ref_count - refs_before, 3);
        for (int i = 0; i < 256; i += 17) access(0, 2'b11, 8'(i), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<200000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule